// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block sits between an instruction fetch stage and a decoder. It receives 16-bit instruction parcels one at a time, in rising address order, over a valid/ready handshake. From the low bits of the first parcel of each instruction it works out how many parcels the instruction occupies. It then gathers that many parcels and presents the finished instruction as one 192-bit word, together with a parcel-count code, the address of the first parcel and an illegal flag.

Encodings that are reserved are not gathered. They leave at once as a one-parcel result with the illegal flag set. A configuration input turns off the short 16-bit form; with it off, short encodings and misaligned longer instructions are flagged. A flush input discards any partial work and any result not yet taken, for use after a branch redirect.

Top module: `vlen_parcel_asm`

## Requirements
- R1: A first parcel whose bits [1:0] are not 11 is a complete one-parcel instruction, reported with out_len = 1.
- R2: A first parcel with bits [1:0] = 11 and bits [4:2] not 111 starts a two-parcel (32-bit) instruction, out_len = 2.
- R3: Bits [5:0] = 011111 give a three-parcel (48-bit) instruction, out_len = 3. Bits [6:0] = 0111111 give a four-parcel (64-bit) instruction, out_len = 4.
- R4: Bits [6:0] = 1111111 with bits [14:12] = n, where n is 0 to 6, give an instruction of 5 + n parcels, out_len = 5 + n.
- R5: Bits [6:0] = 1111111 with bits [14:12] = 111 is reserved. It is emitted on the cycle after its first parcel is accepted, with out_len = 0, out_illegal = 1 and only that parcel in out_insn. The next parcel starts a new instruction.
- R6: out_insn holds parcel k at bits [16k+15:16k], with the first parcel in bits [15:0]. Every bit above the last parcel is zero. out_addr is the address of the first parcel.
- R7: short_en is sampled with the first parcel. When short_en is 0, a one-parcel encoding sets out_illegal, and a longer instruction whose first parcel address has bit 1 set also sets out_illegal. In all other non-reserved cases out_illegal is 0.
- R8: While out_valid is 1, in_ready is 0. out_valid, out_insn, out_len, out_addr and out_illegal hold until out_ready is 1.
- R9: A cycle with flush = 1 accepts no parcel and clears both the partial instruction and any waiting result. The next accepted parcel is treated as a first parcel.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard partial and waiting instruction |
| short_en | input | 1 | 1 = 16-bit encodings allowed |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel can be accepted |
| in_parcel | input | 16 | Parcel data |
| in_addr | input | ADDR_W | Byte address of the parcel |
| out_valid | output | 1 | Finished instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 192 | Assembled instruction, first parcel lowest |
| out_len | output | 4 | Parcel count, 0 for reserved |
| out_addr | output | ADDR_W | Address of the first parcel |
| out_illegal | output | 1 | Reserved or disallowed encoding |

## Verification
On every cycle, the assertions check these properties: the input side stalls while a result waits, a held result stays stable, a flush empties the output, the top 16 bits of the output are zero, a short opcode reports length 1, and a reserved result carries the illegal flag. Other behaviour can only be shown by the bench's scenarios. These are the parcel counts of the long forms, correct placement of every parcel, the address tag, the alignment rule with short instructions disabled, and a clean restart after a flush in the middle of an instruction. The bench checks them against a parcel-by-parcel reference model.

// File: rtl/vpa_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the parcel assembler.
// Assumes parcels are 16 bits and the longest encoding spans 11 parcels.
package vpa_pkg;
    localparam int PARCEL_W   = 16;
    localparam int MAX_PARCEL = 11;
    localparam int LONG_BASE  = 5;
endpackage

// File: rtl/vpa_len_decode.sv
`timescale 1ns/1ps
// Length decoder: maps the first parcel of an instruction to a parcel count.
// Assumes the parcel is the lowest-address parcel of the instruction.
// Reserved encodings report reserved = 1 and a count of 1.
module vpa_len_decode #(
    parameter int LEN_W = 4
) (
    input  logic [vpa_pkg::PARCEL_W-1:0] parcel,
    output logic [LEN_W-1:0]             n_parcels,
    output logic                         reserved
);
    // Walk the chain of low-order ones to find the length class.
    always_comb begin
        reserved = 1'b0;
        if (parcel[1:0] != 2'b11) begin
            n_parcels = LEN_W'(1);
        end else if (parcel[4:2] != 3'b111) begin
            n_parcels = LEN_W'(2);
        end else if (!parcel[5]) begin
            n_parcels = LEN_W'(3);
        end else if (!parcel[6]) begin
            n_parcels = LEN_W'(4);
        end else if (parcel[14:12] == 3'b111) begin
            n_parcels = LEN_W'(1);
            reserved  = 1'b1;
        end else begin
            n_parcels = LEN_W'(vpa_pkg::LONG_BASE) + LEN_W'(parcel[14:12]);
        end
    end
endmodule

// File: rtl/vpa_collect.sv
`timescale 1ns/1ps
// Collector: stores parcels of one instruction and holds the result until
// it is taken. Assumes take is only asserted while out_valid is low.
module vpa_collect #(
    parameter int NP     = 12,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    localparam int PW    = vpa_pkg::PARCEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take,
    input  logic [PW-1:0]     parcel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  first_len,
    input  logic              first_rsvd,
    input  logic              first_ill,
    input  logic              out_ready,
    output logic              is_first,
    output logic              out_valid,
    output logic [NP*PW-1:0]  out_insn,
    output logic [LEN_W-1:0]  out_len,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_illegal
);
    logic [LEN_W-1:0] cnt_q;

    assign is_first = (cnt_q == '0);

    // Sequence control: parcel counter, result flag, tag, length, flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            out_valid   <= 1'b0;
            out_len     <= '0;
            out_addr    <= '0;
            out_illegal <= 1'b0;
        end else if (flush) begin
            cnt_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (take) begin
                if (is_first) begin
                    out_addr    <= addr;
                    out_illegal <= first_ill;
                    out_len     <= first_rsvd ? '0 : first_len;
                    if (first_rsvd || first_len == LEN_W'(1)) begin
                        out_valid <= 1'b1;
                    end else begin
                        cnt_q <= LEN_W'(1);
                    end
                end else if (cnt_q + LEN_W'(1) == out_len) begin
                    out_valid <= 1'b1;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= cnt_q + LEN_W'(1);
                end
            end
        end
    end

    // One storage slot per parcel position.
    for (genvar k = 0; k < NP; k++) begin : g_slot
        logic [PW-1:0] slot_q;
        // Load this slot; a first parcel zeroes all higher slots.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (take && !flush) begin
                if (is_first) begin
                    slot_q <= (k == 0) ? parcel : '0;
                end else if (cnt_q == LEN_W'(k)) begin
                    slot_q <= parcel;
                end
            end
        end
        assign out_insn[k*PW +: PW] = slot_q;
    end
endmodule

// File: rtl/vlen_parcel_asm.sv
`timescale 1ns/1ps
// Top: variable-length instruction parcel assembler.
// Accepts 16-bit parcels in rising address order and emits whole
// instructions left-justified. Assumes in_addr is even.
module vlen_parcel_asm #(
    parameter int ADDR_W      = 32,
    parameter int OUT_PARCELS = 12,
    localparam int OUT_W      = OUT_PARCELS * vpa_pkg::PARCEL_W,
    localparam int LEN_W      = $clog2(vpa_pkg::MAX_PARCEL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              short_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_parcel,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_insn,
    output logic [LEN_W-1:0]  out_len,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_illegal
);
    logic [LEN_W-1:0] dec_len;
    logic             dec_rsvd;
    logic             first_ill;
    logic             take;
    logic             is_first;

    vpa_len_decode #(.LEN_W(LEN_W)) dec_i (
        .parcel    (in_parcel),
        .n_parcels (dec_len),
        .reserved  (dec_rsvd)
    );

    // Ready depends only on held state and flush, never on in_valid.
    assign in_ready = !out_valid && !flush;
    assign take     = in_valid && in_ready;

    // Legality of a first parcel under the current configuration.
    always_comb begin
        if (dec_rsvd)                    first_ill = 1'b1;
        else if (dec_len == LEN_W'(1))   first_ill = !short_en;
        else                             first_ill = !short_en && in_addr[1];
    end

    vpa_collect #(.NP(OUT_PARCELS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) col_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .take        (take),
        .parcel      (in_parcel),
        .addr        (in_addr),
        .first_len   (dec_len),
        .first_rsvd  (dec_rsvd),
        .first_ill   (first_ill),
        .out_ready   (out_ready),
        .is_first    (is_first),
        .out_valid   (out_valid),
        .out_insn    (out_insn),
        .out_len     (out_len),
        .out_addr    (out_addr),
        .out_illegal (out_illegal)
    );
endmodule

// File: rtl/vpa_checker.sv
`timescale 1ns/1ps
// Checker: protocol and output-shape properties of the parcel assembler.
module vpa_checker #(
    parameter int ADDR_W = 32,
    parameter int OUT_W  = 192,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_insn,
    input logic [LEN_W-1:0]  out_len,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_illegal
);
    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
        (out_valid && $stable(out_insn) && $stable(out_addr) && $stable(out_len))); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_insn[OUT_W-1:OUT_W-16] == '0)); // R6
    AST_SHORT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_insn[1:0] != 2'b11) |-> (out_len == LEN_W'(1))); // R1
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == '0) |-> out_illegal); // R5
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len <= LEN_W'(11))); // R4
endmodule

bind vlen_parcel_asm vpa_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_insn    (out_insn),
    .out_len     (out_len),
    .out_addr    (out_addr),
    .out_illegal (out_illegal)
);

// File: tb/vlen_parcel_asm_tb_top.sv
`timescale 1ns/1ps
module vlen_parcel_asm_tb_top;
    localparam int AW = 32;
    localparam int OW = 192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          short_en = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_parcel = '0;
    logic [AW-1:0] in_addr = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [OW-1:0] out_insn;
    logic [3:0]    out_len;
    logic [AW-1:0] out_addr;
    logic          out_illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vlen_parcel_asm dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .short_en(short_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_parcel(in_parcel),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_insn(out_insn), .out_len(out_len), .out_addr(out_addr),
        .out_illegal(out_illegal)
    );

    // Reference model state
    int            m_cnt = 0;
    int            m_len = 0;
    logic [OW-1:0] m_buf = '0;
    logic [AW-1:0] m_addr = '0;
    logic          m_ill = 1'b0;
    logic [OW-1:0] q_insn[$];
    int            q_len[$];
    logic [AW-1:0] q_addr[$];
    logic          q_ill[$];

    logic [15:0] directed[7] = '{16'h0000, 16'h607F, 16'h707F, 16'h003F,
                                 16'h001F, 16'h0003, 16'h107F};
    int dir_idx = 0;

    // Parcel count from the first parcel; 0 marks reserved.
    function automatic int ref_len(input logic [15:0] p);
        if (p[1:0] != 2'b11)          return 1;
        if (p[4:2] != 3'b111)         return 2;
        if (p[5:0] == 6'b011111)      return 3;
        if (p[6:0] == 7'b0111111)     return 4;
        if (p[14:12] == 3'b111)       return 0;
        return 5 + int'(p[14:12]);
    endfunction

    function automatic string tag_of(input int len);
        case (len)
            0: return "R5";
            1: return "R1";
            2: return "R2";
            3, 4: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [15:0] gen_first();
        logic [15:0] p = 16'($urandom);
        int c = $urandom % 8;
        if (c < 3) begin
            if (p[1:0] == 2'b11) p[1:0] = 2'($urandom % 3);
        end else if (c < 5) begin
            p[1:0] = 2'b11;
            if (p[4:2] == 3'b111) p[4:2] = 3'($urandom % 7);
        end else if (c == 5) p[5:0] = 6'b011111;
        else if (c == 6)     p[6:0] = 7'b0111111;
        else                 p[6:0] = 7'b1111111;
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next_parcel();
        if (m_cnt == 0) begin
            if (dir_idx < 7) begin
                in_parcel = directed[dir_idx];
                dir_idx++;
            end else begin
                in_parcel = gen_first();
            end
        end else begin
            in_parcel = 16'($urandom);
        end
    endtask

    task automatic model_take();
        if (m_cnt == 0) begin
            m_len  = ref_len(in_parcel);
            m_buf  = '0;
            m_buf[15:0] = in_parcel;
            m_addr = in_addr;
            if (m_len == 0)      m_ill = 1'b1;
            else if (m_len == 1) m_ill = !short_en;
            else                 m_ill = !short_en && in_addr[1];
            if (m_len <= 1) begin
                q_insn.push_back(m_buf); q_len.push_back(m_len);
                q_addr.push_back(m_addr); q_ill.push_back(m_ill);
            end else begin
                m_cnt = 1;
            end
        end else begin
            m_buf[16*m_cnt +: 16] = in_parcel;
            m_cnt++;
            if (m_cnt == m_len) begin
                q_insn.push_back(m_buf); q_len.push_back(m_len);
                q_addr.push_back(m_addr); q_ill.push_back(m_ill);
                m_cnt = 0;
            end
        end
    endtask

    initial begin
        #(300000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        in_addr = 32'h0000_1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after reset", OW'(out_valid), '0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", OW'(in_ready), OW'(1));
        next_parcel();
        for (int cyc = 0; cyc < 20000; cyc++) begin
            bit do_take;
            bit do_pop;
            // Output side checks against the model queue
            check(out_valid == (q_len.size() != 0), "R8", "out_valid",
                  OW'(out_valid), OW'(q_len.size() != 0));
            if (out_valid && q_len.size() != 0) begin
                check(out_len == 4'(q_len[0]), tag_of(q_len[0]), "out_len",
                      OW'(out_len), OW'(q_len[0]));
                check(out_insn == q_insn[0], "R6", "out_insn", out_insn, q_insn[0]);
                check(out_addr == q_addr[0], "R6", "out_addr", OW'(out_addr), OW'(q_addr[0]));
                check(out_illegal == q_ill[0], (q_len[0] == 0) ? "R5" : "R7",
                      "out_illegal", OW'(out_illegal), OW'(q_ill[0]));
            end
            // Drive stimulus for the next edge
            flush     = ($urandom % 80) == 0;
            out_ready = ($urandom % 4) != 0;
            in_valid  = ($urandom % 5) != 0;
            if (($urandom % 200) == 0) short_en = ~short_en;
            #1;
            check(in_ready == (q_len.size() == 0 && !flush), flush ? "R9" : "R8",
                  "in_ready", OW'(in_ready), OW'(q_len.size() == 0 && !flush));
            do_take = in_valid && in_ready;
            do_pop  = out_valid && out_ready;
            @(negedge clk);
            if (flush) begin
                m_cnt = 0;
                q_insn.delete(); q_len.delete(); q_addr.delete(); q_ill.delete();
                in_addr = {16'($urandom), 15'($urandom), 1'b0};
                check(out_valid == 1'b0, "R9", "out_valid after flush", OW'(out_valid), '0);
                next_parcel();
            end else begin
                if (do_pop) begin
                    void'(q_insn.pop_front()); void'(q_len.pop_front());
                    void'(q_addr.pop_front()); void'(q_ill.pop_front());
                end
                if (do_take) begin
                    model_take();
                    in_addr = in_addr + 2;
                    next_parcel();
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule